// File: doc/BRIEF.md
# Dual-Mode Configuration Load Controller

This block holds the configuration words of a programmable fabric model and moves them into the registers that the running design uses. It has two separate arrays. The storage array receives new words. The active registers drive the fabric. A word reaches the fabric only through an initialization transfer, which copies the storage array into the active registers one word per cycle.

The block has two ways to load a new pattern. In halting mode the fabric stops and its outputs are released. The storage array is erased first and then accepts new words. Exiting the mode runs the transfer, and the new pattern then configures the fabric. In live mode the fabric keeps running from the active registers while the storage array is rewritten. The new pattern takes effect only when live mode is exited or at the next power-up reset. Both of those start the same transfer.

Top module: `cfg_load_ctrl`

## Requirements
- R1: While `rst_n` is low and during the transfer that follows it, `out_en` is 0 and `busy` is 1.
- R2: From the cycle after a halting-mode request is accepted until the transfer that ends the session has finished, `out_en` stays 0.
- R3: Entering halting mode erases all 64 words to 16'hFFFF, one word per cycle, with `busy` high for exactly 64 cycles. Words that are not rewritten afterwards read 16'hFFFF once the session ends.
- R4: In halting mode, after the erase, a write (`wr_en`=1) stores `wr_data` at `wr_addr`, and after exit that word appears on `act_word` when `act_addr` selects it.
- R5: In live mode `out_en` stays 1, and writes leave every active word unchanged until the mode is exited.
- R6: An exit command (`cmd_op`=2'b11) from live mode transfers the storage array, and the live-mode writes then appear on `act_word`.
- R7: The storage array is kept across `rst_n`. The transfer after reset makes the stored pattern active, including words written in live mode that was never exited.
- R8: A write during an erase or a transfer is discarded and sets `err`. `err` stays set until the next accepted halting (2'b01) or live (2'b10) entry, which clears it. `cmd_op`=2'b00 means no command.
- R9: Every transfer takes 64 cycles. `done` is high for exactly one cycle after the last word is copied, with `out_en` still 0, and `out_en` rises in the cycle after the pulse.
- R10: A halting request made while live mode is active is rejected: the block stays in live mode with `busy` 0 and `out_en` 1, and it keeps accepting writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset; starts a transfer on release |
| cmd_op | input | 2 | Command: 00 none, 01 halting entry, 10 live entry, 11 exit |
| wr_en | input | 1 | Write strobe for the storage array |
| wr_addr | input | 6 | Storage word address |
| wr_data | input | 16 | Storage word data |
| act_addr | input | 6 | Selects the active word to observe |
| act_word | output | 16 | Active register contents at `act_addr` |
| busy | output | 1 | Erase or transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| err | output | 1 | Sticky flag: a write arrived while blocked |
| out_en | output | 1 | User output enable; also the run enable of the fabric |

## Verification
The hardest case to reach is a write that arrives in the middle of a transfer after a live exit, aimed at a word the transfer has not copied yet. If such a write leaked into storage, it would show up directly in the active registers. The bench issues the write to the last address during the first transfer cycle. It first places a known live-mode value there, so the later sweep of the active words can tell a discarded write from an accepted one. A write that lands partway through the erase is checked the same way, using a word the erase has already passed.

// File: rtl/cfg_load_pkg.sv
`timescale 1ns/1ps
package cfg_load_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_HALT = 2'b01,
    OP_LIVE = 2'b10,
    OP_EXIT = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_XFER,
    ST_FIN,
    ST_RUN,
    ST_ERASE,
    ST_HLOAD,
    ST_LIVE
  } st_e;

  // true when an index is the final word of an array of the given depth
  function automatic logic at_end(input int unsigned idx, input int unsigned depth);
    return idx == depth - 1;
  endfunction

  // blocked window: erase or any part of the transfer
  function automatic logic is_blocked(input st_e s);
    return (s == ST_XFER) || (s == ST_FIN) || (s == ST_ERASE);
  endfunction

endpackage

// File: rtl/cfg_seq.sv
`timescale 1ns/1ps
module cfg_seq
  import cfg_load_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cmd_op,
  input  logic          wr_en,
  output logic [AW-1:0] cnt,
  output logic          erase_we,
  output logic          xfer_we,
  output logic          wr_ok,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          out_en
);

  st_e  state;
  op_e  op;
  logic halt_rej;
  logic wr_block;

  assign op       = op_e'(cmd_op);
  assign wr_block = wr_en && is_blocked(state);
  assign halt_rej = (state == ST_LIVE) && (op == OP_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_XFER;
      cnt   <= '0;
      err   <= 1'b0;
    end else begin
      case (state)
        ST_XFER: begin
          cnt <= cnt + 1'b1;
          if (at_end(int'(cnt), DEPTH)) begin
            cnt   <= '0;
            state <= ST_FIN;
          end
        end
        ST_FIN:  state <= ST_RUN;
        ST_RUN: begin
          if (op == OP_HALT) begin
            state <= ST_ERASE;
            cnt   <= '0;
            err   <= 1'b0;
          end else if (op == OP_LIVE) begin
            state <= ST_LIVE;
            err   <= 1'b0;
          end
        end
        ST_ERASE: begin
          cnt <= cnt + 1'b1;
          if (at_end(int'(cnt), DEPTH)) begin
            cnt   <= '0;
            state <= ST_HLOAD;
          end
        end
        ST_HLOAD, ST_LIVE: begin
          if (op == OP_EXIT) begin
            state <= ST_XFER;
            cnt   <= '0;
          end
        end
        default: state <= ST_XFER;
      endcase
      if (wr_block) err <= 1'b1;
    end
  end

  assign erase_we = (state == ST_ERASE);
  assign xfer_we  = (state == ST_XFER);
  assign wr_ok    = wr_en && ((state == ST_HLOAD) || (state == ST_LIVE));
  assign busy     = (state == ST_XFER) || (state == ST_ERASE);
  assign done     = (state == ST_FIN);
  assign out_en   = (state == ST_RUN) || (state == ST_LIVE);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  oe_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> $past(done));

  // R10
  halt_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_rej |=> (state == ST_LIVE));

  // R3
  erase_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_we) |-> ($past(cnt) == AW'(DEPTH - 1)));

endmodule

// File: rtl/cfg_store.sv
`timescale 1ns/1ps
module cfg_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          erase_we,
  input  logic [AW-1:0] erase_addr,
  input  logic          wr_ok,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  // kept across reset: this array models the retained configuration
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (erase_we)   mem[erase_addr] <= '1;
    else if (wr_ok) mem[wr_addr]    <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/cfg_active.sv
`timescale 1ns/1ps
module cfg_active #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [AW-1:0] sel_addr,
  output logic [DW-1:0] sel_data
);

  logic [DW-1:0] act [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              act[i] <= '0;
      else if (ld && (ld_addr == AW'(i)))      act[i] <= ld_data;
    end
  end

  assign sel_data = act[sel_addr];

endmodule

// File: rtl/cfg_load_ctrl.sv
`timescale 1ns/1ps
module cfg_load_ctrl #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cmd_op,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] act_addr,
  output logic [DW-1:0] act_word,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          out_en
);

  logic [AW-1:0] cnt;
  logic          erase_we;
  logic          xfer_we;
  logic          wr_ok;
  logic [DW-1:0] xfer_data;

  cfg_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .wr_en(wr_en),
    .cnt(cnt), .erase_we(erase_we), .xfer_we(xfer_we), .wr_ok(wr_ok),
    .busy(busy), .done(done), .err(err), .out_en(out_en)
  );

  cfg_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .erase_we(erase_we), .erase_addr(cnt),
    .wr_ok(wr_ok), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(cnt), .rd_data(xfer_data)
  );

  cfg_active #(.DW(DW), .DEPTH(DEPTH)) u_active (
    .clk(clk), .rst_n(rst_n), .ld(xfer_we), .ld_addr(cnt),
    .ld_data(xfer_data), .sel_addr(act_addr), .sel_data(act_word)
  );

  // R5
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> !xfer_we);

  // R8
  blocked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ok);

  // R2
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_we |-> !out_en);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && busy) |=> err);

endmodule

// File: tb/tb_cfg_load_ctrl.sv
`timescale 1ns/1ps
module tb_cfg_load_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  act_addr = '0;
  logic [15:0] act_word;
  logic        busy, done, err, out_en;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [15:0] m_store [DEPTH];
  logic [15:0] m_act   [DEPTH];

  cfg_load_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .act_addr(act_addr),
    .act_word(act_word), .busy(busy), .done(done), .err(err), .out_en(out_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] blank_word();
    return 16'hFFFF;
  endfunction

  function automatic int xfer_len();
    return DEPTH;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op);
    @(negedge clk); cmd_op = op;
    @(negedge clk); cmd_op = 2'b00;
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] d, input bit track);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (track) m_store[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // counts edges until done is seen; optional blocked write in the first cycle
  task automatic wait_done(input string req, input bit inj);
    int n = 0;
    bit oe_bad = 1'b0;
    if (inj) begin wr_en = 1'b1; wr_addr = 6'd63; wr_data = 16'hBEEF; end
    while (n < 500) begin
      @(negedge clk);
      wr_en = 1'b0;
      n++;
      if (out_en) oe_bad = 1'b1;
      if (done) break;
    end
    chk(n == xfer_len(), req, "transfer length", n, xfer_len());
    chk(!oe_bad, "R2", "out_en low during transfer", oe_bad, 0);
    @(negedge clk);
    chk(!done && out_en, req, "done single pulse then out_en", {done, out_en}, 2'b01);
    for (int i = 0; i < DEPTH; i++) m_act[i] = m_store[i];
  endtask

  task automatic sweep(input string req);
    int bad = 0;
    int ba = 0;
    logic [15:0] bv = '0;
    for (int a = 0; a < DEPTH; a++) begin
      act_addr = 6'(a);
      #0.1;
      if (act_word !== m_act[a]) begin
        if (bad == 0) begin ba = a; bv = act_word; end
        bad++;
      end
    end
    chk(bad == 0, req, $sformatf("active word %0d", ba), bv, m_act[ba]);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!out_en && busy, "R1", "reset state busy/out_en", {busy, out_en}, 2'b10);
    rst_n = 1'b1;
    wait_done("R9", 1'b0);
    chk(!err, "R1", "err after reset", err, 0);

    // halting session with a write landing inside the erase
    do_cmd(2'b01);
    begin
      int n = 0;
      bit oe_bad = 1'b0;
      while (busy && n < 500) begin
        n++;
        wr_en = (n == 5); wr_addr = 6'd3; wr_data = 16'h1234;
        if (out_en) oe_bad = 1'b1;
        @(negedge clk);
      end
      wr_en = 1'b0;
      chk(n == 64, "R3", "erase busy cycles", n, 64);
      chk(!oe_bad && !out_en, "R2", "out_en during erase", out_en, 0);
    end
    chk(err, "R8", "err after write during erase", err, 1);
    for (int i = 0; i < DEPTH; i++) m_store[i] = blank_word();
    for (int k = 0; k < 20; k++) begin
      do_write(6'($urandom_range(8, 63)), 16'($urandom), 1'b1);
      chk(!out_en, "R2", "out_en during load", out_en, 0);
    end
    do_write(6'd8, 16'h0000, 1'b1);
    do_cmd(2'b11);
    wait_done("R9", 1'b0);
    sweep("R4");
    act_addr = 6'd3; #0.1;
    chk(act_word == blank_word(), "R8", "erase-time write discarded", act_word, blank_word());

    // live session
    do_cmd(2'b10);
    chk(!err, "R8", "err cleared on live entry", err, 0);
    begin
      bit oe_bad = 1'b0;
      for (int k = 0; k < 16; k++) begin
        do_write(6'($urandom_range(0, 62)), 16'($urandom), 1'b1);
        if (!out_en) oe_bad = 1'b1;
      end
      do_write(6'd63, 16'h0F0F, 1'b1);
      chk(!oe_bad && out_en, "R5", "out_en in live", out_en, 1);
    end
    sweep("R5");
    do_cmd(2'b01);
    chk(!busy && out_en, "R10", "halt rejected in live", {busy, out_en}, 2'b01);
    do_write(6'd4, 16'hA5A5, 1'b1);
    chk(!busy && out_en, "R10", "still live after reject", {busy, out_en}, 2'b01);
    do_cmd(2'b11);
    wait_done("R6", 1'b1);
    chk(err, "R8", "err after write during transfer", err, 1);
    sweep("R6");

    // second halting session, no writes: all blank
    do_cmd(2'b01);
    chk(!err, "R8", "err cleared on halt entry", err, 0);
    chk(busy && !out_en, "R3", "erase started", {busy, out_en}, 2'b10);
    while (busy) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) m_store[i] = blank_word();
    do_cmd(2'b11);
    wait_done("R9", 1'b0);
    sweep("R3");

    // live writes then power-up reset without exit
    do_cmd(2'b10);
    for (int k = 0; k < 12; k++) do_write(6'($urandom_range(0, 63)), 16'($urandom), 1'b1);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!out_en && busy && !done, "R1", "in reset", {busy, out_en}, 2'b10);
    rst_n = 1'b1;
    wait_done("R7", 1'b0);
    sweep("R7");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule